// File: doc/BRIEF.md
# Accumulator Middle-Word Logic Unit

This unit executes the bitwise instructions whose first opcode nybble is 3. Each cycle in which `issueValid` is high it decodes a 16-bit instruction word. It then combines the middle 16 bits of one of two 40-bit accumulators with a second operand. That operand is either the high half of one of two auxiliary registers, or the middle word of the other accumulator. The single exception is the inversion operation, which uses no second operand. The unit returns the rewritten accumulator through a writeback port. Alongside it comes a zero/sign status pair computed from the full 40-bit result and a one-instruction program-counter step.

The upper nine bits of the word are the main opcode. The lower seven bits form an extension opcode, which another unit executes. This unit forwards it as an 8-bit value whose top bit is forced to zero. Bit 7 of the word chooses between two instruction families that share the same upper bits. Words this unit does not own are flagged so that another unit can pick them up. All outputs are registered and appear one clock after the issue cycle.

Top module: `mwl_unit`

## Requirements
- R1: With bit 7 clear, words 0011 00sd, 0011 01sd and 0011 10sd (bits 15:8) give XOR, AND and OR, respectively, of the middle word of accumulator d with the auxiliary high half s. Here d is bit 8 and s is bit 9.
- R2: With bit 7 clear, words 0011 110d and 0011 111d give AND and OR, respectively, of the middle word of accumulator d with the middle word of the other accumulator.
- R3: With bit 7 set, word 0011 000d XORs the middle word of accumulator d with the middle word of the other accumulator, and 0011 001d inverts every bit of it.
- R4: A writeback changes only bits 31:16 of the destination. Bits 39:32 and 15:0 are copied unchanged from it, and `wrSel` names the destination d.
- R5: `zeroFlag` is high exactly when all 40 bits of the written value are zero, and `signFlag` equals bit 39 of it. Both are valid in the cycle of `wrEn`.
- R6: During `wrEn`, `extOp` equals a zero bit followed by instruction bits 6:0. At all other times it is zero.
- R7: A word with first nybble 3, bit 7 set and bits 11:10 not 00 raises `notMine` for one cycle, with no `wrEn` and no `pcStep`.
- R8: An issued word whose first nybble is not 3 raises `notMine`, with no `wrEn` and no `pcStep`.
- R9: Results appear exactly one cycle after issue. `pcStep` pulses together with every `wrEn`, and a cycle with `issueValid` low produces no `wrEn`, `pcStep` or `notMine`.
- R10: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Instruction word is presented this cycle |
| instWord | input | 16 | Instruction word |
| acc0In | input | 40 | Current value of accumulator 0 |
| acc1In | input | 40 | Current value of accumulator 1 |
| aux0Hi | input | 16 | High half of auxiliary register 0 |
| aux1Hi | input | 16 | High half of auxiliary register 1 |
| wrEn | output | 1 | Writeback strobe |
| wrSel | output | 1 | Destination accumulator index |
| wrAcc | output | 40 | New destination accumulator value |
| zeroFlag | output | 1 | Written value is zero |
| signFlag | output | 1 | Bit 39 of written value |
| pcStep | output | 1 | Advance program counter by one |
| extOp | output | 8 | Extension opcode for the companion unit |
| notMine | output | 1 | Issued word is not executed here |

## Verification
The writeback with its flags and the hand-off of the extension opcode happen in the same output cycle. A wrong split of the word between main opcode and extension therefore corrupts one while the other still looks plausible. The bench issues back-to-back words whose extension bits run through many values, including all-ones, with bit 7 in both states. A scoreboard judges every output cycle against the expected accumulator, the flags and `extOp` together. It also requires `extOp` to stay zero whenever nothing is written.

// File: rtl/mwl_pkg.sv
package mwl_pkg;
  parameter int ACC_W  = 40;
  parameter int MID_W  = 16;
  parameter int LO_W   = 16;
  parameter int INST_W = 16;
  parameter int EXT_W  = 8;
  localparam int HI_W   = ACC_W - MID_W - LO_W;
  localparam int MID_HI = LO_W + MID_W - 1;
  localparam int NUM_ACC = 2;

  typedef enum logic [1:0] {
    LOP_XOR = 2'd0,
    LOP_AND = 2'd1,
    LOP_OR  = 2'd2,
    LOP_NOT = 2'd3
  } lopKind_t;

  typedef struct packed {
    logic             fire;
    logic             notMine;
    lopKind_t         kind;
    logic             useAux;
    logic             srcIdx;
    logic             dstIdx;
    logic [EXT_W-1:0] ext;
  } lgCtrl_t;
endpackage

// File: rtl/mwl_ctrl.sv
module mwl_ctrl
  import mwl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [INST_W-1:0] instWord,
  output lgCtrl_t           ctrlOut
);
  logic       isMine;
  logic       famBit;
  logic [1:0] grp;

  assign isMine = (instWord[15:12] == 4'h3);
  assign famBit = instWord[7];
  assign grp    = instWord[11:10];

  always_comb begin
    ctrlOut = '0;
    ctrlOut.srcIdx = instWord[9];
    ctrlOut.dstIdx = instWord[8];
    if (issueValid) begin
      if (!isMine) begin
        ctrlOut.notMine = 1'b1;
      end else if (!famBit) begin
        ctrlOut.fire = 1'b1;
        case (grp)
          2'b00: begin ctrlOut.kind = LOP_XOR; ctrlOut.useAux = 1'b1; end
          2'b01: begin ctrlOut.kind = LOP_AND; ctrlOut.useAux = 1'b1; end
          2'b10: begin ctrlOut.kind = LOP_OR;  ctrlOut.useAux = 1'b1; end
          default: begin
            ctrlOut.kind   = instWord[9] ? LOP_OR : LOP_AND;
            ctrlOut.useAux = 1'b0;
          end
        endcase
      end else if (grp == 2'b00) begin
        ctrlOut.fire   = 1'b1;
        ctrlOut.useAux = 1'b0;
        ctrlOut.kind   = instWord[9] ? LOP_NOT : LOP_XOR;
      end else begin
        ctrlOut.notMine = 1'b1;
      end
      if (ctrlOut.fire) ctrlOut.ext = {1'b0, instWord[EXT_W-2:0]};
    end
  end

  AST_FOREIGN_NYBBLE: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && instWord[15:12] != 4'h3) |-> (ctrlOut.notMine && !ctrlOut.fire)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !issueValid |-> (!ctrlOut.fire && !ctrlOut.notMine)); // R9
  AST_FAMILY_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && isMine && instWord[7] && instWord[11:10] != 2'b00) |-> ctrlOut.notMine); // R7
endmodule

// File: rtl/mwl_dp.sv
module mwl_dp
  import mwl_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  lgCtrl_t          ctrlIn,
  input  logic [ACC_W-1:0] acc0In,
  input  logic [ACC_W-1:0] acc1In,
  input  logic [MID_W-1:0] aux0Hi,
  input  logic [MID_W-1:0] aux1Hi,
  output logic             wrEn,
  output logic             wrSel,
  output logic [ACC_W-1:0] wrAcc,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             pcStep,
  output logic [EXT_W-1:0] extOp,
  output logic             notMine
);
  logic [ACC_W-1:0] accArr [NUM_ACC];
  logic [MID_W-1:0] midArr [NUM_ACC];
  logic [MID_W-1:0] auxArr [NUM_ACC];

  assign accArr[0] = acc0In;
  assign accArr[1] = acc1In;
  assign auxArr[0] = aux0Hi;
  assign auxArr[1] = aux1Hi;

  for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_mid
    assign midArr[gi] = accArr[gi][MID_HI:LO_W];
  end

  logic [ACC_W-1:0] dstAcc;
  logic [MID_W-1:0] dstMid;
  logic [MID_W-1:0] operand;
  logic [MID_W-1:0] resMid;
  logic [ACC_W-1:0] nextAcc;

  assign dstAcc  = accArr[ctrlIn.dstIdx];
  assign dstMid  = midArr[ctrlIn.dstIdx];
  assign operand = ctrlIn.useAux ? auxArr[ctrlIn.srcIdx] : midArr[~ctrlIn.dstIdx];

  always_comb begin
    case (ctrlIn.kind)
      LOP_XOR: resMid = dstMid ^ operand;
      LOP_AND: resMid = dstMid & operand;
      LOP_OR:  resMid = dstMid | operand;
      default: resMid = ~dstMid;
    endcase
  end

  assign nextAcc = {dstAcc[ACC_W-1 -: HI_W], resMid, dstAcc[LO_W-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn     <= 1'b0;
      wrSel    <= 1'b0;
      wrAcc    <= '0;
      zeroFlag <= 1'b0;
      signFlag <= 1'b0;
      pcStep   <= 1'b0;
      extOp    <= '0;
      notMine  <= 1'b0;
    end else begin
      wrEn    <= ctrlIn.fire;
      pcStep  <= ctrlIn.fire;
      notMine <= ctrlIn.notMine;
      extOp   <= ctrlIn.ext;
      if (ctrlIn.fire) begin
        wrSel    <= ctrlIn.dstIdx;
        wrAcc    <= nextAcc;
        zeroFlag <= (nextAcc == '0);
        signFlag <= nextAcc[ACC_W-1];
      end else begin
        wrSel    <= 1'b0;
        wrAcc    <= '0;
        zeroFlag <= 1'b0;
        signFlag <= 1'b0;
      end
    end
  end

  AST_WR_OR_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && notMine)); // R7
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAcc[LO_W-1:0] == (wrSel ? $past(acc1In[LO_W-1:0]) : $past(acc0In[LO_W-1:0]))); // R4
  AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> wrAcc[ACC_W-1 -: HI_W] == (wrSel ? $past(acc1In[ACC_W-1 -: HI_W]) : $past(acc0In[ACC_W-1 -: HI_W]))); // R4
  AST_SIGN_FROM_DST: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> signFlag == wrAcc[ACC_W-1]); // R5
  AST_STEP_WITH_WR: assert property (@(posedge clk) disable iff (!rstN)
    pcStep |-> (wrEn && $past(ctrlIn.fire))); // R9
  AST_EXT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> extOp == '0); // R6
endmodule

// File: rtl/mwl_unit.sv
module mwl_unit
  import mwl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [INST_W-1:0] instWord,
  input  logic [ACC_W-1:0]  acc0In,
  input  logic [ACC_W-1:0]  acc1In,
  input  logic [MID_W-1:0]  aux0Hi,
  input  logic [MID_W-1:0]  aux1Hi,
  output logic              wrEn,
  output logic              wrSel,
  output logic [ACC_W-1:0]  wrAcc,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              pcStep,
  output logic [EXT_W-1:0]  extOp,
  output logic              notMine
);
  lgCtrl_t ctrlBus;

  mwl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .instWord   (instWord),
    .ctrlOut    (ctrlBus)
  );

  mwl_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlIn   (ctrlBus),
    .acc0In   (acc0In),
    .acc1In   (acc1In),
    .aux0Hi   (aux0Hi),
    .aux1Hi   (aux1Hi),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrAcc    (wrAcc),
    .zeroFlag (zeroFlag),
    .signFlag (signFlag),
    .pcStep   (pcStep),
    .extOp    (extOp),
    .notMine  (notMine)
  );
endmodule

// File: tb/sim_mwl_unit.sv
`timescale 1ns/1ps
module sim_mwl_unit;
  localparam time HALF = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [15:0] instWord = '0;
  logic [39:0] acc0In = '0, acc1In = '0;
  logic [15:0] aux0Hi = '0, aux1Hi = '0;
  logic        wrEn, wrSel, zeroFlag, signFlag, pcStep, notMine;
  logic [39:0] wrAcc;
  logic [7:0]  extOp;

  always #HALF clk = ~clk;

  mwl_unit u0 (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .instWord(instWord),
    .acc0In(acc0In), .acc1In(acc1In), .aux0Hi(aux0Hi), .aux1Hi(aux1Hi),
    .wrEn(wrEn), .wrSel(wrSel), .wrAcc(wrAcc), .zeroFlag(zeroFlag),
    .signFlag(signFlag), .pcStep(pcStep), .extOp(extOp), .notMine(notMine)
  );

  typedef struct {
    logic        wr;
    logic        nm;
    logic        sel;
    logic [39:0] acc;
    logic        z;
    logic        s;
    logic [7:0]  ext;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic v, input logic [15:0] w, input logic [39:0] a0, input logic [39:0] a1,
                       input logic [15:0] x0, input logic [15:0] x1);
    expItem_t e;
    logic [39:0] d;
    logic [15:0] m, o, r;
    bit ok;
    @(negedge clk);
    issueValid = v; instWord = w; acc0In = a0; acc1In = a1; aux0Hi = x0; aux1Hi = x1;
    e = '{wr:0, nm:0, sel:0, acc:'0, z:0, s:0, ext:'0};
    if (v) begin
      d = w[8] ? a1 : a0;
      m = d[31:16];
      o = w[8] ? a0[31:16] : a1[31:16];
      ok = 1;
      r = '0;
      if (w[15:12] != 4'h3) ok = 0;
      else if (!w[7]) begin
        case (w[11:10])
          2'b00: r = m ^ (w[9] ? x1 : x0);
          2'b01: r = m & (w[9] ? x1 : x0);
          2'b10: r = m | (w[9] ? x1 : x0);
          default: r = w[9] ? (m | o) : (m & o);
        endcase
      end else if (w[11:10] == 2'b00) r = w[9] ? (m ^ 16'hFFFF) : (m ^ o);
      else ok = 0;
      if (ok) begin
        e.wr = 1; e.sel = w[8];
        e.acc = {d[39:32], r, d[15:0]};
        e.z = (e.acc == 40'd0); e.s = e.acc[39];
        e.ext = {1'b0, w[6:0]};
      end else e.nm = 1;
    end
    expQ.push_back(e);
  endtask

  initial begin : monitor
    expItem_t e;
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        chk(wrEn == e.wr, "R1/R2/R3 wrEn", {39'd0, wrEn}, {39'd0, e.wr});
        chk(notMine == e.nm, "R7/R8 notMine", {39'd0, notMine}, {39'd0, e.nm});
        chk(pcStep == e.wr, "R9 pcStep", {39'd0, pcStep}, {39'd0, e.wr});
        if (e.wr) begin
          chk(wrSel == e.sel, "R4 wrSel", {39'd0, wrSel}, {39'd0, e.sel});
          chk(wrAcc == e.acc, "R1/R2/R3/R4 wrAcc", wrAcc, e.acc);
          chk(zeroFlag == e.z, "R5 zeroFlag", {39'd0, zeroFlag}, {39'd0, e.z});
          chk(signFlag == e.s, "R5 signFlag", {39'd0, signFlag}, {39'd0, e.s});
          chk(extOp == e.ext, "R6 extOp", {32'd0, extOp}, {32'd0, e.ext});
        end else begin
          chk(extOp == 8'h00, "R6 extOp idle", {32'd0, extOp}, 40'd0);
        end
      end
    end
  end

  initial begin : watchdog
    #(2 * HALF * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  localparam logic [39:0] A0 = 40'h12_A5C3_0F0F;
  localparam logic [39:0] A1 = 40'h80_3C3C_F00D;

  initial begin : driver
    repeat (3) @(posedge clk);
    #1;
    chk({wrEn, pcStep, notMine, zeroFlag, signFlag, wrSel} == 6'd0, "R10 reset flags",
        {34'd0, wrEn, pcStep, notMine, zeroFlag, signFlag, wrSel}, 40'd0);
    chk(wrAcc == 40'd0, "R10 reset wrAcc", wrAcc, 40'd0);
    chk(extOp == 8'd0, "R10 reset extOp", {32'd0, extOp}, 40'd0);
    @(negedge clk); rstN = 1'b1;

    // R1: aux operand, each op, both s and d
    issue(1, 16'h3000, A0, A1, 16'h00FF, 16'hFF00);
    issue(1, 16'h3300, A0, A1, 16'h00FF, 16'hFF00);
    issue(1, 16'h3512, A0, A1, 16'h00FF, 16'hFF00);
    issue(1, 16'h3A7F, A0, A1, 16'h1111, 16'h8001);
    issue(1, 16'h3901, A0, A1, 16'h1111, 16'h8001);
    // R2: other accumulator middle word
    issue(1, 16'h3C00, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3D55, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3E2A, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3F7F, A0, A1, 16'h0, 16'h0);
    // R3: bit-7 family, XOR other and invert
    issue(1, 16'h3080, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h31FF, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3281, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3390, A0, A1, 16'h0, 16'h0);
    // R5: zero result and sign
    issue(1, 16'h3080, 40'h00_BEEF_0000, 40'h00_BEEF_0000, 16'h0, 16'h0);
    issue(1, 16'h3280, 40'h00_FFFF_0000, 40'h55_0000_0000, 16'h0, 16'h0);
    issue(1, 16'h3100, 40'hFF_1234_0000, A1, 16'h0, 16'h0);
    // R7: bit-7 words outside this unit
    issue(1, 16'h3480, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3BFF, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3D80, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3FC1, A0, A1, 16'h0, 16'h0);
    // R8: foreign first nybble
    issue(1, 16'h4000, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h2C7F, A0, A1, 16'h0, 16'h0);
    issue(1, 16'hB080, A0, A1, 16'h0, 16'h0);
    // R9: idle cycles with a valid-looking word
    issue(0, 16'h3000, A0, A1, 16'hFFFF, 16'hFFFF);
    issue(0, 16'h4000, A0, A1, 16'h0, 16'h0);
    issue(1, 16'h3C00, A0, A1, 16'h0, 16'h0);
    // mixed back-to-back traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = $urandom;
      if (i % 4 != 3) w[15:12] = 4'h3;
      issue(($urandom % 8) != 0, w, {$urandom, $urandom} & 40'hFF_FFFF_FFFF,
            {$urandom, $urandom} & 40'hFF_FFFF_FFFF, $urandom, $urandom);
    end
    issue(0, 16'h0, '0, '0, '0, '0);
    issue(0, 16'h0, '0, '0, '0, '0);
    repeat (3) @(posedge clk);
    #2;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule